// File: doc/BRIEF.md
# Gain-State Controller with Hold and Bypass

This block decides, cycle by cycle, whether a front-end amplifier should run at full gain or at reduced gain. It watches a sampled signal-strength code and asserts a one-bit reduction request as soon as that code reaches an upper threshold. The request is withdrawn only after the code has remained below a separate, lower threshold for an unbroken stretch of clock cycles. The gap between the two thresholds gives hysteresis, so the amplifier does not chatter between its two gain settings.

Two asynchronous control inputs steer the loop. One powers the block up or down. The other selects the mode. While powered, a rising mode edge freezes the present gain setting, and a falling mode edge hands control back to the automatic loop. If the mode input is already high when power comes up, the loop starts bypassed with full gain forced. Mode activity while powered down changes nothing. Only the mode level seen at the next power-up edge counts. Both control inputs are resynchronised to the clock before any edge is detected. A two-bit state output reports what the controller is doing.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While `rst` is high, or while the synchronised `pwr_en` is low, `gain_low` is 0, the release count is cleared and `agc_state` reads 3.
- R2: While running, a sampled `sig_code` greater than or equal to `THR_HIGH` makes `gain_low` 1 after the next clock edge.
- R3: While running at reduced gain, `gain_low` returns to 0 after `RELEASE_CYC` consecutive sampled codes below `THR_LOW`.
- R4: A code at or above `THR_LOW` before the release count expires restarts the count from zero. Codes in the band from `THR_LOW` to `THR_HIGH - 1` leave `gain_low` unchanged.
- R5: If the synchronised mode input is high on the cycle that power rises, the controller enters the bypassed state. In that state `gain_low` stays 0 whatever the code.
- R6: A rising edge of the synchronised mode input while running and powered enters the frozen state. `gain_low` then keeps its value, 0 or 1, whatever the code.
- R7: A falling edge of the synchronised mode input while powered, from the frozen or bypassed state, returns to automatic running with the release count restarted.
- R8: Changes of `mode_in` while powered down have no effect. On power-up only the mode level at that edge decides between running and bypassed.
- R9: `pwr_en` and `mode_in` each pass through two flops before use. A change on either first affects the outputs after the third rising clock edge.
- R10: `agc_state` encodes 0 for running at full gain, 1 for running at reduced gain, 2 for frozen and 3 for bypassed or powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power/enable request, asynchronous |
| mode_in | input | 1 | Mode control, asynchronous (edge freezes, level at power-up bypasses) |
| sig_code | input | CODE_W | Sampled signal-strength code, synchronous to clk |
| gain_low | output | 1 | 1 requests reduced amplifier gain |
| agc_state | output | 2 | Controller state code (see R10) |

## Verification
The bench builds the controller with `THR_HIGH = 600`, `THR_LOW = 400` and `RELEASE_CYC = 6`. The default release of about 50,000 cycles drops to a handful of cycles. Full releases, restarts one cycle before expiry and a release that resumes after a freeze can therefore all be exercised in a few hundred clocks. The thresholds sit well inside the 10-bit code range, so the bench can probe the exact values at each threshold, one code below it, and codes in the band between the two.

// File: rtl/agc_pkg.sv
package agc_pkg;

    // Externally visible state code (R10)
    typedef enum logic [1:0] {
        ST_RUN_HIGH = 2'd0,
        ST_RUN_LOW  = 2'd1,
        ST_FROZEN   = 2'd2,
        ST_BYPASS   = 2'd3
    } agc_state_e;

    // Internal control mode
    typedef enum logic [1:0] {
        C_RUN  = 2'd0,
        C_HOLD = 2'd1,
        C_OFF  = 2'd2
    } ctrl_mode_e;

    // Map control mode and gain to the reported state
    function automatic agc_state_e state_of(input ctrl_mode_e m, input logic g);
        case (m)
            C_RUN:   state_of = g ? ST_RUN_LOW : ST_RUN_HIGH;
            C_HOLD:  state_of = ST_FROZEN;
            default: state_of = ST_BYPASS;
        endcase
    endfunction

    // Counter width able to hold 0..n
    function automatic int cnt_width(input int n);
        cnt_width = (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/agc_sync.sv
module agc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/agc_mode_fsm.sv
module agc_mode_fsm
    import agc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_s,
    input  logic       mode_s,
    output ctrl_mode_e ctrl_q,
    output logic       upd_en,
    output logic       force_high
);
    logic       pwr_d, mode_d;
    logic       pwr_rise, mode_rise, mode_fall;
    ctrl_mode_e ctrl_n;

    assign pwr_rise  = pwr_s & ~pwr_d;
    assign mode_rise = mode_s & ~mode_d;
    assign mode_fall = ~mode_s & mode_d;

    always_comb begin
        ctrl_n = ctrl_q;
        if (!pwr_s)                          ctrl_n = C_OFF;
        else if (pwr_rise)                   ctrl_n = mode_s ? C_OFF : C_RUN;
        else if (mode_rise && ctrl_q == C_RUN) ctrl_n = C_HOLD;
        else if (mode_fall)                  ctrl_n = C_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= C_OFF;
            pwr_d  <= 1'b0;
            mode_d <= 1'b0;
        end else begin
            ctrl_q <= ctrl_n;
            pwr_d  <= pwr_s;
            mode_d <= mode_s;
        end
    end

    // Loop updates only in steady powered running without a freeze edge
    assign upd_en     = pwr_s & ~pwr_rise & (ctrl_q == C_RUN) & ~mode_rise;
    assign force_high = ~pwr_s;

    p_off_when_down_r1: assert property (@(posedge clk) disable iff (rst)
        !pwr_s |=> ctrl_q == C_OFF);
    p_pwrup_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_s && !pwr_d && mode_s) |=> ctrl_q == C_OFF);
    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q == C_RUN && pwr_s && pwr_d && mode_s && !mode_d) |=> ctrl_q == C_HOLD);
    p_resume_r7: assert property (@(posedge clk) disable iff (rst)
        (pwr_s && pwr_d && !mode_s && mode_d) |=> ctrl_q == C_RUN);
endmodule

// File: rtl/agc_gain_timer.sv
module agc_gain_timer
    import agc_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int THR_HIGH    = 792,
    parameter int THR_LOW     = 556,
    parameter int RELEASE_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic              force_high,
    input  logic [CODE_W-1:0] sig_code,
    output logic              gain_low
);
    localparam int CNT_W = cnt_width(RELEASE_CYC);
    localparam logic [CODE_W-1:0] HI_C   = CODE_W'(THR_HIGH);
    localparam logic [CODE_W-1:0] LO_C   = CODE_W'(THR_LOW);
    localparam logic [CNT_W-1:0]  LAST_C = CNT_W'(RELEASE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             above_hi, below_lo;

    assign above_hi = (sig_code >= HI_C);
    assign below_lo = (sig_code <  LO_C);

    always_ff @(posedge clk) begin
        if (rst || force_high) begin
            gain_low <= 1'b0;
            cnt_q    <= '0;
        end else if (!upd_en) begin
            cnt_q    <= '0;
        end else if (above_hi) begin
            gain_low <= 1'b1;
            cnt_q    <= '0;
        end else if (gain_low && below_lo) begin
            if (cnt_q == LAST_C) begin
                gain_low <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q    <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q    <= '0;
        end
    end

    p_trip_r2: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !force_high && sig_code >= HI_C) |=> gain_low);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(RELEASE_CYC));
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !below_lo) |=> cnt_q == '0);
    p_force_high_r1: assert property (@(posedge clk) disable iff (rst)
        force_high |=> (!gain_low && cnt_q == '0));
    p_hold_gain_r6: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !force_high) |=> gain_low == $past(gain_low));
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int THR_HIGH    = 792,
    parameter int THR_LOW     = 556,
    parameter int RELEASE_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_en,
    input  logic              mode_in,
    input  logic [CODE_W-1:0] sig_code,
    output logic              gain_low,
    output logic [1:0]        agc_state
);
    logic [1:0] sync_q;
    ctrl_mode_e ctrl_q;
    logic       upd_en, force_high;
    agc_state_e st;

    agc_sync #(.W(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({mode_in, pwr_en}),
        .q_sync  (sync_q)
    );

    agc_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_s      (sync_q[0]),
        .mode_s     (sync_q[1]),
        .ctrl_q     (ctrl_q),
        .upd_en     (upd_en),
        .force_high (force_high)
    );

    agc_gain_timer #(
        .CODE_W      (CODE_W),
        .THR_HIGH    (THR_HIGH),
        .THR_LOW     (THR_LOW),
        .RELEASE_CYC (RELEASE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .upd_en     (upd_en),
        .force_high (force_high),
        .sig_code   (sig_code),
        .gain_low   (gain_low)
    );

    assign st        = state_of(ctrl_q, gain_low);
    assign agc_state = st;

    initial begin
        a_params_r4: assert (THR_LOW < THR_HIGH && RELEASE_CYC >= 1);
    end

    p_bypass_full_gain_r5: assert property (@(posedge clk) disable iff (rst)
        agc_state == 2'd3 |-> !gain_low);
    p_state_gain_r10: assert property (@(posedge clk) disable iff (rst)
        (agc_state == 2'd0 || agc_state == 2'd1) |-> gain_low == agc_state[0]);
endmodule

// File: tb/agc_gain_ctrl_tb_top.sv
module agc_gain_ctrl_tb_top;
    localparam int CODE_W = 10;
    localparam int HI     = 600;
    localparam int LO     = 400;
    localparam int REL    = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pwr_en = 1'b0;
    logic              mode_in = 1'b0;
    logic [CODE_W-1:0] sig_code = '0;
    logic              gain_low;
    logic [1:0]        agc_state;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    agc_gain_ctrl #(
        .CODE_W(CODE_W), .THR_HIGH(HI), .THR_LOW(LO), .RELEASE_CYC(REL)
    ) dut_i (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .mode_in(mode_in),
        .sig_code(sig_code), .gain_low(gain_low), .agc_state(agc_state)
    );

    // Behavioural reference: pipeline delays as integer history, state as plain ints
    int hist_p[2];
    int hist_m[2];
    int last_p, last_m;
    int mode_m;     // 0 running, 1 frozen, 2 off/bypass
    int gain_m;
    int run_len;

    always @(posedge clk) begin
        int p, m, nxt_mode, nxt_gain, nxt_len;
        if (rst) begin
            hist_p = '{0, 0}; hist_m = '{0, 0};
            last_p = 0; last_m = 0;
            mode_m = 2; gain_m = 0; run_len = 0;
        end else begin
            p = hist_p[1]; m = hist_m[1];
            nxt_mode = mode_m; nxt_gain = gain_m; nxt_len = 0;
            if (p == 0) begin
                nxt_mode = 2; nxt_gain = 0;
            end else if (last_p == 0) begin
                nxt_mode = (m == 1) ? 2 : 0;
            end else if (m == 1 && last_m == 0 && mode_m == 0) begin
                nxt_mode = 1;
            end else begin
                if (m == 0 && last_m == 1) nxt_mode = 0;
                if (mode_m == 0) begin
                    if (int'(sig_code) >= HI) nxt_gain = 1;
                    else if (gain_m == 1 && int'(sig_code) < LO) begin
                        if (run_len + 1 == REL) nxt_gain = 0;
                        else nxt_len = run_len + 1;
                    end
                end
            end
            mode_m = nxt_mode; gain_m = nxt_gain; run_len = nxt_len;
            last_p = p; last_m = m;
            hist_p[1] = hist_p[0]; hist_p[0] = int'(pwr_en);
            hist_m[1] = hist_m[0]; hist_m[0] = int'(mode_in);
        end
    end

    function automatic int exp_state();
        if (mode_m == 2) return 3;
        if (mode_m == 1) return 2;
        return gain_m;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare at the falling edge, then apply the next inputs
    task automatic step(input logic p, input logic m, input int code, input string tag);
        @(negedge clk);
        check(tag, int'(gain_low), gain_m, "gain_low");
        check({tag, "/R10"}, int'(agc_state), exp_state(), "agc_state");
        pwr_en   = p;
        mode_in  = m;
        sig_code = CODE_W'(code);
    endtask

    task automatic steps(input int n, input logic p, input logic m, input int code, input string tag);
        for (int i = 0; i < n; i++) step(p, m, code, tag);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        // Reset state (R1)
        steps(3, 1'b0, 1'b0, 0, "R1");
        @(negedge clk);
        check("R1", int'(gain_low), 0, "gain_low in reset");
        check("R1", int'(agc_state), 3, "agc_state in reset");
        rst = 1'b0;
        steps(3, 1'b0, 1'b0, 0, "R1");

        // Power up running, sync latency (R9)
        steps(5, 1'b1, 1'b0, 300, "R9");
        // Trip exactly at the upper threshold (R2)
        steps(3, 1'b1, 1'b0, 600, "R2");
        // Band between thresholds holds reduced gain (R4)
        steps(4, 1'b1, 1'b0, 599, "R4");
        steps(4, 1'b1, 1'b0, 400, "R4");
        // Count interrupted one cycle before expiry (R4)
        steps(5, 1'b1, 1'b0, 399, "R4");
        steps(1, 1'b1, 1'b0, 450, "R4");
        // Full release (R3)
        steps(8, 1'b1, 1'b0, 399, "R3");
        // One below upper threshold does not trip (R2)
        steps(3, 1'b1, 1'b0, 599, "R2");
        steps(3, 1'b1, 1'b0, 700, "R2");

        // Freeze at reduced gain (R6)
        steps(4, 1'b1, 1'b1, 700, "R6");
        steps(12, 1'b1, 1'b1, 0, "R6");
        // Resume and release (R7)
        steps(10, 1'b1, 1'b0, 0, "R7");
        // Freeze at full gain (R6)
        steps(4, 1'b1, 1'b1, 100, "R6");
        steps(6, 1'b1, 1'b1, 900, "R6");
        steps(5, 1'b1, 1'b0, 900, "R7");

        // Power down (R1) and mode activity while down (R8)
        steps(4, 1'b0, 1'b0, 900, "R1");
        steps(3, 1'b0, 1'b1, 900, "R8");
        steps(3, 1'b0, 1'b0, 900, "R8");
        steps(3, 1'b0, 1'b1, 900, "R8");
        // Power up with mode high: bypass (R5)
        steps(8, 1'b1, 1'b1, 900, "R5");
        // Leave bypass (R7)
        steps(6, 1'b1, 1'b0, 900, "R7");
        // Down, toggle mode, come back with mode low (R8)
        steps(3, 1'b0, 1'b1, 900, "R8");
        steps(4, 1'b0, 1'b0, 900, "R8");
        steps(5, 1'b1, 1'b0, 900, "R8");
        @(negedge clk);
        check("R8", int'(agc_state), 1, "running low after clean power-up");
        check("R2", int'(gain_low), 1, "tripped after power-up");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule